// File: doc/BRIEF.md
# Dual-Comparator Timer with Output Pin Logic

This block is a 10-bit up-counting timer with two comparators that together drive one output pin. Comparator A matches the full counter value. Comparator P matches a coarse 3-bit value against the top of the counter. The timer has four modes. In plain timer mode only the event flags are used. In compare-match mode the pin is set, cleared or toggled on an A match. PWM mode gives a periodic waveform. Single-pulse mode gives one active pulse after each start.

Software sets a run bit and a small set of configuration fields. While the run bit is high the counter advances on every clock. While it is low the counter and the pin hold their values. The counter can be cleared by either comparator, so the period of the timer can be set. In PWM mode the roles of the two comparators, period and duty, can be swapped. A rising edge of the run bit starts a new output sequence from a programmable initial level.

Top module: `cmp_timer`

## Requirements
- R1: After synchronous reset the pin is low and the A-match, P-match and overflow flags are all low.
- R2: While `run` is high the counter increments by one on every clock. While `run` is low the counter, the flags' sources and the pin level are all frozen.
- R3: Each flag is a one-cycle pulse on the clock edge after the running counter equals its target. For A the target is `cmp_a`. For P the target is `cmp_p` followed by seven zero bits, and a `cmp_p` of 0 means 1023. Overflow fires after the counter reaches 1023.
- R4: In timer and compare modes (`mode` 00 and 01), `clr_sel`=1 returns the counter to 0 after an A match, which gives a period of `cmp_a`+1 cycles. With `clr_sel`=0 the counter returns to 0 after a P match, which gives a period of `cmp_p`*128+1 cycles, or 1024 cycles by overflow when `cmp_p`=0.
- R5: In compare mode (`mode`=01), an A match applies the action code to the raw pin level: 00 leaves it, 01 drives it low, 10 drives it high, 11 inverts it.
- R6: In compare mode, a rising edge of `run` sets the raw pin level to `oc`. A match whose requested level equals the current level leaves the pin unchanged.
- R7: In PWM mode (`mode`=10) with swap 0, P sets the period and A sets the duty. The raw pin equals `oc` (the active level) for `cmp_a`+1 of every `cmp_p`*128+1 cycles, and equals the opposite level for the rest.
- R8: In PWM mode with swap 1, A sets the period (`cmp_a`+1 cycles) and the P target sets the duty, so the pin is active for P-target+1 cycles.
- R9: In single-pulse mode (`mode`=11), a rising edge of `run` makes the raw pin equal to `oc`. After the duty match it goes to the inactive level and stays there until the next rising edge of `run`.
- R10: Outside timer mode the pin is the raw level XOR `pol`. In timer mode the pin stays low whatever `oc` and `pol` are.
- R11: Changes to the action code and the swap bit made while `run` is high have no effect until `run` has been low for at least one cycle.
- R12: `clr_sel` is ignored in PWM and single-pulse modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| run | input | 1 | Run enable; its rising edge starts a sequence |
| mode | input | 2 | 00 timer, 01 compare, 10 PWM, 11 single pulse |
| act | input | 2 | Compare action: 00 none, 01 low, 10 high, 11 toggle |
| oc | input | 1 | Initial level (compare mode) or active level (PWM and pulse modes) |
| pol | input | 1 | Inverts the pin when set |
| swap | input | 1 | PWM role swap: 0 means P is the period, 1 means A is the period |
| clr_sel | input | 1 | Counter clear source: 1 means A match, 0 means P match or overflow |
| cmp_a | input | 10 | Comparator A value |
| cmp_p | input | 3 | Comparator P value (top counter bits) |
| pin | output | 1 | Output pin level |
| match_a | output | 1 | Comparator A match pulse |
| match_p | output | 1 | Comparator P match pulse |
| ovf | output | 1 | Counter overflow pulse |

## Verification
The restart checks assume that `mode`, `oc` and `pol` are held steady across the cycle that follows a rising edge of `run`. The bench always changes configuration while the timer is stopped, or before the first start after a reset, so this holds. The bench always changes the action code and the swap bit on their own, so their held-until-restart behaviour can be seen. It also keeps PWM duty targets below the period target so that each period has exactly one duty match, and it starts every scenario from reset so that the counter begins at zero.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;
  typedef enum logic [1:0] {
    MD_TIMER = 2'b00,
    MD_CMP   = 2'b01,
    MD_PWM   = 2'b10,
    MD_PULSE = 2'b11
  } mode_e;

  typedef enum logic [1:0] {
    ACT_HOLD   = 2'b00,
    ACT_LOW    = 2'b01,
    ACT_HIGH   = 2'b10,
    ACT_TOGGLE = 2'b11
  } act_e;

  // Raw pin level after a compare action is applied.
  function automatic logic apply_action(input act_e a, input logic cur);
    case (a)
      ACT_LOW:    return 1'b0;
      ACT_HIGH:   return 1'b1;
      ACT_TOGGLE: return ~cur;
      default:    return cur;
    endcase
  endfunction
endpackage

// File: rtl/ctm_count.sv
module ctm_count #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt_q,
  output logic             wrap
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  assign wrap = run && (cnt_q == CNT_MAX);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (run) begin
      if (clr) cnt_q <= '0;
      else     cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/ctm_compare.sv
module ctm_compare #(
  parameter int CNT_W = 10,
  parameter int PW    = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] cmp_a,
  input  logic [PW-1:0]    cmp_p,
  input  logic             wrap,
  output logic             eq_a,
  output logic             eq_p,
  output logic             match_a,
  output logic             match_p,
  output logic             ovf
);
  localparam int LOW_W = CNT_W - PW;

  // P target: coarse value in the top bits; zero stands for the full range.
  function automatic logic [CNT_W-1:0] p_target(input logic [PW-1:0] p);
    if (p == '0) return {CNT_W{1'b1}};
    return {p, {LOW_W{1'b0}}};
  endfunction

  assign eq_a = run && (cnt == cmp_a);
  assign eq_p = run && (cnt == p_target(cmp_p));

  always_ff @(posedge clk) begin
    if (rst) begin
      match_a <= 1'b0;
      match_p <= 1'b0;
      ovf     <= 1'b0;
    end else begin
      match_a <= eq_a;
      match_p <= eq_p;
      ovf     <= wrap;
    end
  end
endmodule

// File: rtl/ctm_pin.sv
module ctm_pin
  import cmp_timer_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  run,
  input  mode_e mode,
  input  act_e  act,
  input  logic  swap,
  input  logic  oc,
  input  logic  pol,
  input  logic  eq_a,
  input  logic  eq_p,
  output logic  run_rise,
  output logic  period_hit,
  output logic  duty_hit,
  output logic  pin
);
  logic  run_q;
  act_e  act_l;
  logic  swap_l;
  logic  st_q;
  logic  st_nx;

  assign run_rise   = run && !run_q;
  assign period_hit = swap_l ? eq_a : eq_p;
  assign duty_hit   = swap_l ? eq_p : eq_a;

  always_comb begin
    st_nx = st_q;
    case (mode)
      MD_CMP: begin
        if (run_rise)  st_nx = oc;
        else if (eq_a) st_nx = apply_action(act_l, st_q);
      end
      MD_PWM: begin
        if (run_rise)        st_nx = oc;
        else if (duty_hit)   st_nx = ~oc;
        else if (period_hit) st_nx = oc;
      end
      MD_PULSE: begin
        if (run_rise)      st_nx = oc;
        else if (duty_hit) st_nx = ~oc;
      end
      default: st_nx = st_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= 1'b0;
      act_l  <= ACT_HOLD;
      swap_l <= 1'b0;
      st_q   <= 1'b0;
    end else begin
      run_q <= run;
      if (!run) begin
        act_l  <= act;
        swap_l <= swap;
      end
      st_q <= st_nx;
    end
  end

  assign pin = (mode == MD_TIMER) ? 1'b0 : (st_q ^ pol);
endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
  import cmp_timer_pkg::*;
#(
  parameter int CNT_W = 10,
  parameter int PW    = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [1:0]       mode,
  input  logic [1:0]       act,
  input  logic             oc,
  input  logic             pol,
  input  logic             swap,
  input  logic             clr_sel,
  input  logic [CNT_W-1:0] cmp_a,
  input  logic [PW-1:0]    cmp_p,
  output logic             pin,
  output logic             match_a,
  output logic             match_p,
  output logic             ovf
);
  mode_e            mode_t;
  logic [CNT_W-1:0] cnt_q;
  logic             wrap;
  logic             eq_a;
  logic             eq_p;
  logic             run_rise;
  logic             period_hit;
  logic             duty_hit;
  logic             cnt_clr;
  logic             wave_mode;

  assign mode_t    = mode_e'(mode);
  assign wave_mode = (mode_t == MD_PWM) || (mode_t == MD_PULSE);
  assign cnt_clr   = wave_mode ? period_hit : (clr_sel ? eq_a : eq_p);

  ctm_count #(.CNT_W(CNT_W)) u_count (
    .clk   (clk),
    .rst   (rst),
    .run   (run),
    .clr   (cnt_clr),
    .cnt_q (cnt_q),
    .wrap  (wrap)
  );

  ctm_compare #(.CNT_W(CNT_W), .PW(PW)) u_cmp (
    .clk     (clk),
    .rst     (rst),
    .run     (run),
    .cnt     (cnt_q),
    .cmp_a   (cmp_a),
    .cmp_p   (cmp_p),
    .wrap    (wrap),
    .eq_a    (eq_a),
    .eq_p    (eq_p),
    .match_a (match_a),
    .match_p (match_p),
    .ovf     (ovf)
  );

  ctm_pin u_pin (
    .clk        (clk),
    .rst        (rst),
    .run        (run),
    .mode       (mode_t),
    .act        (act_e'(act)),
    .swap       (swap),
    .oc         (oc),
    .pol        (pol),
    .eq_a       (eq_a),
    .eq_p       (eq_p),
    .run_rise   (run_rise),
    .period_hit (period_hit),
    .duty_hit   (duty_hit),
    .pin        (pin)
  );
endmodule

// File: rtl/cmp_timer_chk.sv
module cmp_timer_chk #(
  parameter int CNT_W = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             run,
  input logic [1:0]       mode,
  input logic             oc,
  input logic             pol,
  input logic [CNT_W-1:0] cmp_a,
  input logic             pin,
  input logic             match_a,
  input logic             ovf,
  input logic [CNT_W-1:0] cnt,
  input logic             cnt_clr,
  input logic             run_rise
);
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  a_r2_freeze: assert property (@(posedge clk) disable iff (rst)
    !run |=> $stable(cnt));

  a_r2_step: assert property (@(posedge clk) disable iff (rst)
    (run && !cnt_clr) |=> cnt == CNT_W'($past(cnt) + 1'b1));

  a_r4_clear: assert property (@(posedge clk) disable iff (rst)
    (run && cnt_clr) |=> cnt == '0);

  a_r3_match_a: assert property (@(posedge clk) disable iff (rst)
    (run && cnt == cmp_a) |=> match_a);

  a_r3_ovf_src: assert property (@(posedge clk) disable iff (rst)
    ovf |-> ($past(cnt) == CMAX) && $past(run));

  a_r6_restart: assert property (@(posedge clk) disable iff (rst)
    (run_rise && mode == 2'b01) |=> (mode != 2'b01) || ((pin ^ pol) == $past(oc)));

  a_r9_pulse_start: assert property (@(posedge clk) disable iff (rst)
    (run_rise && mode == 2'b11) |=> (mode != 2'b11) || ((pin ^ pol) == $past(oc)));
endmodule

bind cmp_timer cmp_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .run      (run),
  .mode     (mode),
  .oc       (oc),
  .pol      (pol),
  .cmp_a    (cmp_a),
  .pin      (pin),
  .match_a  (match_a),
  .ovf      (ovf),
  .cnt      (cnt_q),
  .cnt_clr  (cnt_clr),
  .run_rise (run_rise)
);

// File: tb/cmp_timer_bench.sv
module cmp_timer_bench;
  logic       clk = 1'b0;
  logic       rst, run, oc, pol, swap, clr_sel;
  logic [1:0] mode, act;
  logic [9:0] cmp_a;
  logic [2:0] cmp_p;
  logic       pin, match_a, match_p, ovf;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  cmp_timer u_cmp_timer (
    .clk(clk), .rst(rst), .run(run), .mode(mode), .act(act), .oc(oc),
    .pol(pol), .swap(swap), .clr_sel(clr_sel), .cmp_a(cmp_a), .cmp_p(cmp_p),
    .pin(pin), .match_a(match_a), .match_p(match_p), .ovf(ovf)
  );

  // Bench view of the P target: value times 128, zero meaning 1023.
  function automatic int p_span(input int p);
    return (p == 0) ? 1023 : p * 128;
  endfunction

  task automatic check(input bit ok, input string req, input int got, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; run = 1'b0; mode = 2'b00; act = 2'b00; oc = 1'b0; pol = 1'b0;
    swap = 1'b0; clr_sel = 1'b0; cmp_a = '0; cmp_p = '0;
    step(2);
    rst = 1'b0;
  endtask

  task automatic count_high(input int len, output int h);
    h = 0;
    for (int i = 0; i < len; i++) begin
      step(1);
      if (pin) h++;
    end
  endtask

  task automatic wait_match_a(output int waited);
    waited = 0;
    while (!match_a && waited < 2000) begin
      step(1);
      waited++;
    end
  endtask

  task automatic t_reset();
    do_reset();
    step(1);
    check(pin == 1'b0, "R1 pin", pin, 0);
    check({match_a, match_p, ovf} == 3'b000, "R1 flags", {match_a, match_p, ovf}, 0);
  endtask

  task automatic t_timer_a_clear();
    int bad;
    do_reset();
    mode = 2'b00; clr_sel = 1'b1; cmp_a = 10'd5; cmp_p = 3'd2; oc = 1'b1; pol = 1'b1;
    run = 1'b1;
    bad = 0;
    for (int i = 1; i <= 18; i++) begin
      step(1);
      if (match_a != ((i % 6) == 0)) bad++;
      if (pin) bad += 100;
    end
    check(bad == 0, "R4 A clear period / R10 timer pin low", bad, 0);
    step(2);  // counter now 2
    run = 1'b0;
    bad = 0;
    for (int i = 0; i < 10; i++) begin
      step(1);
      if (match_a) bad++;
    end
    check(bad == 0, "R2 frozen no match", bad, 0);
    run = 1'b1;
    step(3);
    check(match_a == 1'b0, "R2 resume early", match_a, 0);
    step(1);
    check(match_a == 1'b1, "R2 resume continues from held count", match_a, 1);
  endtask

  task automatic t_timer_p_clear();
    int first, np, na;
    do_reset();
    mode = 2'b01; clr_sel = 1'b0; cmp_p = 3'd1; cmp_a = 10'd1000; act = 2'b00;
    run = 1'b1;
    first = 0; np = 0; na = 0;
    for (int i = 1; i <= 260; i++) begin
      step(1);
      if (match_p) begin
        np++;
        if (first == 0) first = i;
      end
      if (match_a) na++;
    end
    check(first == p_span(1) + 1, "R3 P match timing", first, p_span(1) + 1);
    check(np == 2, "R4 P clear period", np, 2);
    check(na == 0, "R4 A never reached", na, 0);
  endtask

  task automatic t_overflow();
    int first;
    do_reset();
    mode = 2'b00; clr_sel = 1'b0; cmp_p = 3'd0; cmp_a = 10'd1023;
    run = 1'b1;
    first = 0;
    for (int i = 1; i <= 1030; i++) begin
      step(1);
      if (ovf && first == 0) begin
        first = i;
        check(match_p && match_a, "R3 P and A at full range", {match_p, match_a}, 3);
      end
    end
    check(first == 1024, "R3 overflow timing", first, 1024);
  endtask

  task automatic t_compare_actions();
    // drive high, initial low
    do_reset();
    mode = 2'b01; clr_sel = 1'b1; cmp_a = 10'd3; oc = 1'b0; act = 2'b10;
    step(1);
    run = 1'b1;
    step(3);
    check(pin == 1'b0, "R6 initial low", pin, 0);
    step(1);
    check(pin == 1'b1, "R5 drive high", pin, 1);
    step(1);
    run = 1'b0;
    step(3);
    check(pin == 1'b1, "R2 pin held while stopped", pin, 1);
    run = 1'b1;
    step(1);
    check(pin == 1'b0, "R6 restart restores initial", pin, 0);
    // toggle
    do_reset();
    mode = 2'b01; clr_sel = 1'b1; cmp_a = 10'd3; oc = 1'b0; act = 2'b11;
    step(1);
    run = 1'b1;
    step(4);
    check(pin == 1'b1, "R5 toggle first", pin, 1);
    step(4);
    check(pin == 1'b0, "R5 toggle second", pin, 0);
    // drive low equal to initial low
    do_reset();
    mode = 2'b01; clr_sel = 1'b1; cmp_a = 10'd3; oc = 1'b0; act = 2'b01;
    step(1);
    run = 1'b1;
    step(4);
    check(match_a == 1'b1 && pin == 1'b0, "R6 same level no change", pin, 0);
    // drive low from initial high, plus inversion
    do_reset();
    mode = 2'b01; clr_sel = 1'b1; cmp_a = 10'd3; oc = 1'b1; act = 2'b01; pol = 1'b1;
    step(1);
    run = 1'b1;
    step(1);
    check(pin == 1'b0, "R10 inverted initial high", pin, 0);
    step(3);
    check(pin == 1'b1, "R5 drive low inverted", pin, 1);
    // hold code
    do_reset();
    mode = 2'b01; clr_sel = 1'b1; cmp_a = 10'd3; oc = 1'b1; act = 2'b00;
    step(1);
    run = 1'b1;
    step(4);
    check(match_a == 1'b1 && pin == 1'b1, "R5 hold code", pin, 1);
  endtask

  task automatic t_action_held();
    int w;
    do_reset();
    mode = 2'b01; clr_sel = 1'b1; cmp_a = 10'd7; oc = 1'b1; act = 2'b10;
    step(1);
    run = 1'b1;
    step(2);
    act = 2'b01;
    wait_match_a(w);
    check(pin == 1'b1, "R11 action change held while running", pin, 1);
    step(1);
    run = 1'b0;
    step(1);
    run = 1'b1;
    step(1);
    check(pin == 1'b1, "R6 restart level", pin, 1);
    wait_match_a(w);
    check(pin == 1'b0, "R11 new action after restart", pin, 0);
  endtask

  task automatic t_pwm();
    int h, per;
    per = p_span(1) + 1;
    do_reset();
    mode = 2'b10; swap = 1'b0; oc = 1'b1; cmp_p = 3'd1; cmp_a = 10'd40; clr_sel = 1'b1;
    step(1);
    run = 1'b1;
    step(128);
    swap = 1'b1;
    count_high(per, h);
    check(h == 41, "R7 PWM duty / R11 swap held / R12 clr_sel ignored", h, 41);
    do_reset();
    mode = 2'b10; oc = 1'b0; cmp_p = 3'd1; cmp_a = 10'd40;
    step(1);
    run = 1'b1;
    step(128);
    count_high(per, h);
    check(h == per - 41, "R7 PWM active low", h, per - 41);
    do_reset();
    mode = 2'b10; oc = 1'b1; pol = 1'b1; cmp_p = 3'd1; cmp_a = 10'd40;
    step(1);
    run = 1'b1;
    step(128);
    count_high(per, h);
    check(h == per - 41, "R10 PWM inverted", h, per - 41);
  endtask

  task automatic t_pwm_swap();
    int h;
    do_reset();
    mode = 2'b10; swap = 1'b1; oc = 1'b1; cmp_p = 3'd1; cmp_a = 10'd299; clr_sel = 1'b0;
    step(1);
    run = 1'b1;
    step(299);
    count_high(300, h);
    check(h == p_span(1) + 1, "R8 swapped roles", h, p_span(1) + 1);
  endtask

  task automatic t_pulse();
    int h;
    do_reset();
    mode = 2'b11; swap = 1'b0; oc = 1'b1; cmp_p = 3'd1; cmp_a = 10'd20; clr_sel = 1'b1;
    step(1);
    run = 1'b1;
    count_high(300, h);
    check(h == 20, "R9 single pulse width / R12", h, 20);
    check(pin == 1'b0, "R9 stays inactive", pin, 0);
    run = 1'b0;
    step(1);
    run = 1'b1;
    step(1);
    check(pin == 1'b1, "R9 restart active", pin, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_timer_a_clear();
    t_timer_p_clear();
    t_overflow();
    t_compare_actions();
    t_action_held();
    t_pwm();
    t_pwm_swap();
    t_pulse();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule